// File: doc/BRIEF.md
# HDLC Framing Encoder with NRZI Line Coding

This block turns a raw payload held in an external byte buffer into a complete serial HDLC frame for a downstream modulator. The host writes the payload length in bits into a length register and then pulses a start input. The encoder then produces one line bit for every strobe from the modulator's bit clock. Each frame carries an alternating training run, an opening flag, the payload, a 16-bit frame check sequence and a closing flag, in that order.

Zero bits are stuffed into the payload and check sequence only. The entire stream leaves the block NRZI coded. The payload is read from the buffer one byte at a time, through an address the block drives itself. The length is given in bits, so a frame may end partway through a byte.

When the frame is over, a done flag rises and the line level holds. A new frame can then be started.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After reset `tx_bit` is 1, and `busy` and `done` are 0.
- R2: A frame accepted by `go` begins with 24 training bits of alternating value, the first one being 0.
- R3: The training run is followed by the flag byte 0x7E, sent least significant bit first. The same flag closes the frame after the check sequence. Flag bits are never stuffed and never count toward a run of ones.
- R4: The payload follows the opening flag. It consists of exactly `len` bits. Bit i is bit (i mod 8) of buffer byte i/8, so each byte goes out least significant bit first. With a length of 0 the payload is skipped.
- R5: After the payload come 16 check bits, least significant bit first. They are the complement of a reflected CRC-16 over the payload bits, using polynomial constant 0x8408 and preset 0xFFFF.
- R6: Within the payload and check bits, a 0 is inserted after every fifth consecutive 1. The run continues across the payload/check boundary. A run of five that ends on the last check bit gets its 0 before the closing flag.
- R7: The line is NRZI coded: a coded 0 toggles `tx_bit` and a coded 1 holds it. `tx_bit` changes only in the cycle after a strobe.
- R8: The strobe after the last closing-flag bit sets `done` and clears `busy`, and `tx_bit` holds its level. `done` stays set until the next accepted `go`.
- R9: While `busy` is set, `go` and length writes are ignored. The running frame is unchanged, and the next frame uses the length written before the running frame began.
- R10: A written length above 1376 bits (172 bytes) is stored as 1376.
- R11: `rd_addr` never reaches 172 while a frame runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_wr | input | 1 | Write strobe for the payload length register |
| len_val | input | 11 | Payload length in bits |
| go | input | 1 | Start a frame (taken only while idle) |
| bit_stb | input | 1 | One line bit per strobe |
| rd_addr | output | 8 | Buffer byte address |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| tx_bit | output | 1 | NRZI line level |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame complete |

## Verification
The bench runs the following frames, and each one separates a different class of fault:
- An empty payload checks that the data phase is skipped and that the check sequence of nothing is sixteen zeros.
- A 13-bit payload exposes bit-order and partial-byte mistakes.
- An all-ones payload, and bytes equal to the flag value, exercise stuffing and confirm that flags stay unstuffed.
- A mixed payload with widely spaced strobes shows whether the line moves without a strobe.
- A late `go` and a late length write, issued mid-frame, must leave that frame and the following one intact.
- An oversize length with a full buffer tests the clamp and the top address.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_TRAIN,
      PH_OPEN,
      PH_DATA,
      PH_FCS,
      PH_CLOSE,
      PH_TAIL
   } phase_e;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
   parameter int          CRC_W    = 16,
   parameter logic [15:0] CRC_POLY = 16'h8408,
   parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift,
   input  logic             din,
   output logic [CRC_W-1:0] crc_q
);
   localparam logic [CRC_W-1:0] POLY = CRC_POLY[CRC_W-1:0];
   localparam logic [CRC_W-1:0] INIT = CRC_INIT[CRC_W-1:0];

   logic             fb;
   logic [CRC_W-1:0] crc_nx;

   assign fb = crc_q[0] ^ din;

   genvar i;
   generate
      for (i = 0; i < CRC_W - 1; i++) begin : g_bit
         assign crc_nx[i] = crc_q[i+1] ^ (fb & POLY[i]);
      end
   endgenerate
   assign crc_nx[CRC_W-1] = fb & POLY[CRC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= INIT;
      else if (clear)  crc_q <= INIT;
      else if (shift)  crc_q <= crc_nx;
   end
endmodule

// File: rtl/hdlc_tx_stuff.sv
module hdlc_tx_stuff #(
   parameter int STUFF_RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic track,
   input  logic insert,
   input  logic din,
   output logic stuff_now
);
   localparam int RW = $clog2(STUFF_RUN + 1);

   logic [RW-1:0] run_q;

   assign stuff_now = (run_q == RW'(STUFF_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_q <= '0;
      else if (clear || insert)  run_q <= '0;
      else if (track)            run_q <= din ? run_q + 1'b1 : '0;
   end
endmodule

// File: rtl/hdlc_tx_nrzi.sv
module hdlc_tx_nrzi #(
   parameter bit IDLE_LEVEL     = 1'b1,
   parameter bit TOGGLE_ON_ZERO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic din,
   output logic lvl
);
   logic flip;

   generate
      if (TOGGLE_ON_ZERO) begin : g_space
         assign flip = ~din;
      end else begin : g_mark
         assign flip = din;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lvl <= IDLE_LEVEL;
      else if (step && flip)    lvl <= ~lvl;
   end
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
   import hdlc_tx_pkg::*;
#(
   parameter int          BUF_BYTES  = 172,
   parameter int          TRAIN_BITS = 24,
   parameter logic [7:0]  FLAG_BYTE  = 8'h7E,
   parameter int          CRC_W      = 16,
   parameter logic [15:0] CRC_POLY   = 16'h8408,
   parameter logic [15:0] CRC_INIT   = 16'hFFFF,
   parameter int          STUFF_RUN  = 5,
   parameter bit          IDLE_LEVEL = 1'b1,
   localparam int         MAX_BITS   = BUF_BYTES * 8,
   localparam int         LEN_W      = $clog2(MAX_BITS + 1),
   localparam int         ADDR_W     = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_wr,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              go,
   input  logic              bit_stb,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              tx_bit,
   output logic              busy,
   output logic              done
);
   localparam int               CRC_IX  = $clog2(CRC_W);
   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BITS);
   localparam logic [LEN_W-1:0] TR_LAST = LEN_W'(TRAIN_BITS - 1);
   localparam logic [LEN_W-1:0] CR_LAST = LEN_W'(CRC_W - 1);
   localparam logic [LEN_W-1:0] FL_LAST = LEN_W'(7);

   generate
      if (BUF_BYTES < 2) begin : g_chk_buf
         $error("BUF_BYTES must be at least 2");
      end
      if (TRAIN_BITS < 1 || TRAIN_BITS > MAX_BITS) begin : g_chk_train
         $error("TRAIN_BITS out of range");
      end
      if (CRC_W < 8 || CRC_W > 16 || CRC_W != (1 << CRC_IX)) begin : g_chk_crc
         $error("CRC_W must be 8 or 16");
      end
      if (STUFF_RUN < 1) begin : g_chk_run
         $error("STUFF_RUN must be positive");
      end
   endgenerate

   phase_e           phase_q, phase_nx;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] len_q;
   logic             done_q;
   logic [CRC_W-1:0] crc_q;
   logic             raw;
   logic             tx_raw;
   logic             stuff_now;
   logic             emit;
   logic             advance;
   logic             last;
   logic             stuffable;
   logic             go_ok;

   // length register, frozen while a frame runs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (len_wr && phase_q == PH_IDLE)
         len_q <= (len_val > MAX_LEN) ? MAX_LEN : len_val;
   end

   assign go_ok     = go && (phase_q == PH_IDLE);
   assign stuffable = (phase_q == PH_DATA) || (phase_q == PH_FCS);
   assign emit      = bit_stb && (phase_q != PH_IDLE) && (phase_q != PH_TAIL);
   assign tx_raw    = stuff_now ? 1'b0 : raw;
   assign advance   = emit && !stuff_now;

   always_comb begin
      raw      = 1'b1;
      last     = 1'b0;
      phase_nx = phase_q;
      rd_addr  = '0;
      case (phase_q)
         PH_TRAIN: begin
            raw      = cnt_q[0];
            last     = (cnt_q == TR_LAST);
            phase_nx = PH_OPEN;
         end
         PH_OPEN: begin
            raw      = FLAG_BYTE[cnt_q[2:0]];
            last     = (cnt_q == FL_LAST);
            phase_nx = (len_q == '0) ? PH_FCS : PH_DATA;
         end
         PH_DATA: begin
            rd_addr  = ADDR_W'(cnt_q >> 3);
            raw      = rd_data[cnt_q[2:0]];
            last     = (cnt_q == len_q - 1'b1);
            phase_nx = PH_FCS;
         end
         PH_FCS: begin
            raw      = ~crc_q[cnt_q[CRC_IX-1:0]];
            last     = (cnt_q == CR_LAST);
            phase_nx = PH_CLOSE;
         end
         PH_CLOSE: begin
            raw      = FLAG_BYTE[cnt_q[2:0]];
            last     = (cnt_q == FL_LAST);
            phase_nx = PH_TAIL;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else if (phase_q == PH_IDLE) begin
         if (go_ok) begin
            phase_q <= PH_TRAIN;
            cnt_q   <= '0;
            done_q  <= 1'b0;
         end
      end else if (phase_q == PH_TAIL) begin
         if (bit_stb) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
         end
      end else if (advance) begin
         if (last) begin
            phase_q <= phase_nx;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   hdlc_tx_crc #(
      .CRC_W    (CRC_W),
      .CRC_POLY (CRC_POLY),
      .CRC_INIT (CRC_INIT)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (go_ok),
      .shift (advance && phase_q == PH_DATA),
      .din   (raw),
      .crc_q (crc_q)
   );

   hdlc_tx_stuff #(
      .STUFF_RUN (STUFF_RUN)
   ) u_stuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (go_ok),
      .track     (advance && stuffable),
      .insert    (emit && stuff_now),
      .din       (raw),
      .stuff_now (stuff_now)
   );

   hdlc_tx_nrzi #(
      .IDLE_LEVEL     (IDLE_LEVEL),
      .TOGGLE_ON_ZERO (1'b1)
   ) u_nrzi (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (emit),
      .din   (tx_raw),
      .lvl   (tx_bit)
   );

   assign busy = (phase_q != PH_IDLE);
   assign done = done_q;
endmodule

// File: rtl/hdlc_frame_tx_chk.sv
module hdlc_frame_tx_chk #(
   parameter int BUF_BYTES = 172,
   parameter int STUFF_RUN = 5,
   parameter int ADDR_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              go,
   input logic              bit_stb,
   input logic              tx_bit,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              emit_bit,
   input logic              emit_vld,
   input logic              stuffable
);
   localparam int            CW  = $clog2(STUFF_RUN + 2) + 1;
   localparam logic [ADDR_W:0] LIM = (ADDR_W + 1)'(BUF_BYTES);

   logic [CW-1:0] ones_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ones_q <= '0;
      else if (go && !busy)             ones_q <= '0;
      else if (emit_vld && !emit_bit)   ones_q <= '0;
      else if (emit_vld && stuffable && ones_q != '1)
                                        ones_q <= ones_q + 1'b1;
   end

   assert_run_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= CW'(STUFF_RUN));

   assert_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> $stable(tx_bit));

   assert_nrzi_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
      emit_vld |=> (tx_bit == ($past(emit_bit) ? $past(tx_bit) : !$past(tx_bit))));

   assert_done_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(bit_stb));

   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tx_bit));

   assert_start_by_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));

   assert_addr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ({1'b0, rd_addr} < LIM));
endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk #(
   .BUF_BYTES (BUF_BYTES),
   .STUFF_RUN (STUFF_RUN),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .bit_stb   (bit_stb),
   .tx_bit    (tx_bit),
   .busy      (busy),
   .done      (done),
   .rd_addr   (rd_addr),
   .emit_bit  (tx_raw),
   .emit_vld  (emit),
   .stuffable (stuffable)
);

// File: tb/tb_hdlc_frame_tx.sv
`timescale 1ns/1ps
module tb_hdlc_frame_tx;
   localparam int NB    = 172;
   localparam int MAXB  = NB * 8;
   localparam int LW    = 11;
   localparam int AW    = 8;

   typedef struct {
      logic  lvl;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          len_wr = 1'b0;
   logic [LW-1:0] len_val = '0;
   logic          go = 1'b0;
   logic          bit_stb = 1'b0;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;
   logic          tx_bit, busy, done;

   logic [7:0] mem [0:NB-1];
   assign rd_data = (rd_addr < AW'(NB)) ? mem[rd_addr] : 8'h00;

   hdlc_frame_tx dut (
      .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
      .go(go), .bit_stb(bit_stb), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_bit(tx_bit), .busy(busy), .done(done)
   );

   always #5 clk = ~clk;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   ended = 1'b0;
   exp_t exp_q[$];
   logic lvl_m = 1'b1;
   logic stb_seen = 1'b0;
   int   cur_len = 0;

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: one expected line level per strobe taken at the previous edge
   always @(posedge clk) stb_seen <= bit_stb;
   always @(negedge clk) begin
      if (stb_seen && rst_n) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7 unexpected strobe", 0, 1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(tx_bit === e.lvl, e.tag, int'(tx_bit), int'(e.lvl));
         end
         chk(!busy || rd_addr < AW'(NB), "R11 rd_addr", int'(rd_addr), NB - 1);
      end
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   task automatic push_raw(input logic b, input string tag);
      if (!b) lvl_m = ~lvl_m;
      exp_q.push_back('{lvl_m, tag});
   endtask

   task automatic build(input int n);
      logic [15:0] crc;
      logic [15:0] fc;
      int          ones;
      logic        b;
      crc  = 16'hFFFF;
      ones = 0;
      for (int i = 0; i < 24; i++) push_raw(logic'(i % 2), "R2 training");
      for (int i = 0; i < 8; i++)  push_raw(logic'((8'h7E >> i) & 1), "R3 open flag");
      for (int i = 0; i < n + 16; i++) begin
         if (i < n) begin
            b = mem[i / 8][i % 8];
            if (crc[0] ^ b) crc = (crc >> 1) ^ 16'h8408;
            else            crc = crc >> 1;
            if (i == n - 1) fc = ~crc;
            push_raw(b, "R4 payload");
         end else begin
            if (i == n) fc = ~crc;
            b = fc[i - n];
            push_raw(b, "R5 fcs");
         end
         ones = b ? ones + 1 : 0;
         if (ones == 5) begin
            push_raw(1'b0, "R6 stuffed zero");
            ones = 0;
         end
      end
      for (int i = 0; i < 8; i++)  push_raw(logic'((8'h7E >> i) & 1), "R3 close flag");
      exp_q.push_back('{lvl_m, "R8 tail hold"});
   endtask

   task automatic write_len(input int v);
      @(negedge clk);
      len_val = LW'(v);
      len_wr  = 1'b1;
      @(negedge clk);
      len_wr  = 1'b0;
   endtask

   // driver: start a frame, strobe it out with a gap, optionally poke mid-frame
   task automatic run_frame(input int n, input int gap, input bit poke);
      int total;
      logic held;
      build(n);
      total = exp_q.size();
      @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk(busy === 1'b1, "R9 busy after go", int'(busy), 1);
      chk(done === 1'b0, "R8 done cleared by go", int'(done), 0);
      for (int k = 0; k < total; k++) begin
         if (poke && k == 40) begin
            go      = 1'b1;
            len_wr  = 1'b1;
            len_val = LW'(3);
         end
         bit_stb = 1'b1;
         @(negedge clk);
         bit_stb = 1'b0;
         go      = 1'b0;
         len_wr  = 1'b0;
         if (k == total - 2) begin
            chk(done === 1'b0, "R8 done not before tail", int'(done), 0);
            chk(busy === 1'b1, "R8 busy before tail", int'(busy), 1);
         end
         held = tx_bit;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(tx_bit === held, "R7 hold between strobes", int'(tx_bit), int'(held));
         end
      end
      @(negedge clk);
      chk(done === 1'b1, "R8 done set", int'(done), 1);
      chk(busy === 1'b0, "R8 busy clear", int'(busy), 0);
      chk(exp_q.size() == 0, "R8 all bits consumed", exp_q.size(), 0);
      held = tx_bit;
      for (int k = 0; k < 3; k++) begin
         bit_stb = 1'b1;
         @(negedge clk);
         bit_stb = 1'b0;
         exp_q.push_back('{lvl_m, "R8 idle after done"});
         @(negedge clk);
         chk(tx_bit === held, "R8 idle level", int'(tx_bit), int'(held));
         chk(done === 1'b1, "R8 done stays", int'(done), 1);
      end
      exp_q.delete();
   endtask

   initial begin
      for (int i = 0; i < NB; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk(tx_bit === 1'b1, "R1 tx_bit reset", int'(tx_bit), 1);
      chk(busy === 1'b0, "R1 busy reset", int'(busy), 0);
      chk(done === 1'b0, "R1 done reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_bit === 1'b1 && !busy && !done, "R1 after release", int'(tx_bit), 1);

      // empty payload
      write_len(0);
      run_frame(0, 0, 1'b0);

      // 13-bit payload, partial byte
      mem[0] = 8'hA5; mem[1] = 8'h3C;
      write_len(13);
      run_frame(13, 1, 1'b0);

      // all ones: stuffing
      for (int i = 0; i < 5; i++) mem[i] = 8'hFF;
      write_len(40);
      run_frame(40, 0, 1'b0);

      // flag-valued bytes, with mid-frame go and length write (R9)
      for (int i = 0; i < 4; i++) mem[i] = 8'h7E;
      write_len(32);
      run_frame(32, 0, 1'b1);
      // next frame without a write keeps 32 bits (R9)
      run_frame(32, 0, 1'b0);

      // mixed bytes, spaced strobes
      for (int i = 0; i < 6; i++) mem[i] = 8'(i * 37 + 11);
      write_len(45);
      run_frame(45, 3, 1'b0);

      // oversize length clamps to the full buffer (R10, R11)
      for (int i = 0; i < NB; i++) mem[i] = 8'((i * 73) ^ (i >> 2) ^ 8'h5A);
      write_len(2047);
      run_frame(MAXB, 0, 1'b0);

      finish_run();
   end
endmodule